// File: doc/BRIEF.md
# SPI Master/Slave Shift Engine

This block is one channel of a synchronous serial port that moves characters of 1 to 16 bits over SCLK, SDO and SDI. In master role it makes the serial clock itself: a reload counter sets the half period to `reload + 1` operating-clock cycles, so the serial clock runs at the operating clock divided by 2 × (reload + 1). A bypass control drops the counter to a one-cycle half period. In slave role the divider sits unused. The block shifts on edges of the external serial clock pin, which pass through a short synchronizer in the operating-clock domain.

Software writes a character to the transmit data input and reads the received character from `rx_data`. Clock polarity, clock phase, bit order and character length are set independently. When a character completes in either role, the receive-full interrupt is raised. It stays up until a read strobe clears it.

For debug, a halt input freezes the master divider when debug-run is clear. While frozen, SCLK, SDO and all state hold their values, and the transfer continues from the same point after the halt ends. A slave keeps running during a halt.

Top module: `spi_shift_engine`

## Requirements
- R1: After reset, `busy` is 0, `rxfull_irq` is 0, `rx_data` is 0 and `sclk_out` equals `cpol`.
- R2: In master role (`mode_master` = 1), a `tx_wr` pulse while idle starts a transfer. `busy` is 1 on the cycle after the write. A transfer produces exactly 2 × N SCLK edges, where N is the character length. `busy` falls on the cycle of the last edge. SCLK then rests at `cpol`.
- R3: In master role with `div_bypass` = 0, every SCLK half period is `reload + 1` operating-clock cycles, and the first edge comes `reload + 1` cycles after the write is taken.
- R4: With `div_bypass` = 1, the master half period is one operating-clock cycle whatever `reload` holds.
- R5: The leading edge is the transition away from `cpol`. With `cpha` = 0, each bit is on SDO before its leading edge and SDI is sampled on that leading edge. With `cpha` = 1, SDO changes on the leading edge and SDI is sampled on the trailing edge.
- R6: With `lsb_first` = 0, bit N-1 goes out and comes in first (MSB first). With `lsb_first` = 1, bit 0 goes first.
- R7: `char_len` holds N-1: 4'h7 gives 8-bit characters and 4'hF gives 16-bit characters. The received word sits in bits N-1..0 of `rx_data`, and the upper bits read 0.
- R8: Completing a character sets `rxfull_irq` and latches `rx_data`. The flag stays set until an `rx_rd` pulse, which clears it on the next cycle.
- R9: In master role, while `debug_halt` = 1 and `debug_run` = 0, `sclk_out`, `sdo` and `busy` hold their values. The transfer is delayed by exactly the number of halted cycles and then completes with correct data.
- R10: In master role with `debug_run` = 1, `debug_halt` has no effect on timing or data.
- R11: In slave role, shifting follows the edges on `sclk_in`. A `tx_wr` only loads data and does not start a transfer. `reload`, `div_bypass` and `debug_halt` have no effect.
- R12: A `tx_wr` that arrives while `busy` = 1 is ignored: the character in flight and its timing are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Operating clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_master | input | 1 | 1 = master role, 0 = slave role |
| cpol | input | 1 | Clock polarity (idle SCLK level) |
| cpha | input | 1 | Clock phase (0: sample on leading edge) |
| lsb_first | input | 1 | 0 = MSB first, 1 = LSB first |
| char_len | input | 4 | Character length minus one |
| reload | input | RLD_W (16) | Master divider reload value |
| div_bypass | input | 1 | Master half period forced to one cycle |
| debug_halt | input | 1 | CPU is in debug state |
| debug_run | input | 1 | 1 = keep the master running during debug |
| tx_wr | input | 1 | Transmit data write strobe |
| tx_data | input | 16 | Transmit character |
| rx_rd | input | 1 | Receive data read strobe (clears the full flag) |
| rx_data | output | 16 | Last received character |
| busy | output | 1 | Transfer in progress |
| rxfull_irq | output | 1 | Receive buffer full interrupt |
| sclk_in | input | 1 | Serial clock from an external master |
| sclk_out | output | 1 | Serial clock driven in master role |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |

## Verification
The hardest situation to reach is a debug freeze that lands in the middle of a master character. It must stop the divider at an arbitrary count, and the transfer must still finish with every bit in place. The stimulus counts operating-clock cycles from the accepted write and raises the halt a fixed number of cycles in, between two SCLK edges. It then checks that SCLK, SDO and busy stay put for the whole window and that the transfer ends exactly that many cycles late. A slave transfer is also driven with the halt held high throughout, to show that the external clock path ignores it.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    // Width of the character-length field; the longest character is 2**LEN_W bits.
    localparam int LEN_W    = 4;
    localparam int MAX_BITS = 1 << LEN_W;
    // Edge counter: 2*MAX_BITS edges per character, indices 0 .. 2*MAX_BITS-1.
    localparam int ECNT_W   = LEN_W + 1;

    typedef enum logic {
        ROLE_SLAVE  = 1'b0,
        ROLE_MASTER = 1'b1
    } role_e;

    // Frame shape seen by the shift core (polarity is handled at the pin).
    typedef struct packed {
        logic             lsb_first;
        logic             cpha;
        logic [LEN_W-1:0] len_m1;
    } frame_shape_t;

    // Bit lane holding the character bit at serial position pos.
    function automatic logic [LEN_W-1:0] lane_of(input logic [LEN_W-1:0] pos,
                                                  input logic [LEN_W-1:0] len_m1,
                                                  input logic             lsbf);
        lane_of = lsbf ? pos : (len_m1 - pos);
    endfunction

    // Index of the final edge of a character: 2*(len_m1+1)-1.
    function automatic logic [ECNT_W-1:0] final_edge(input logic [LEN_W-1:0] len_m1);
        final_edge = {len_m1, 1'b1};
    endfunction

endpackage

// File: rtl/spi_baud_div.sv
module spi_baud_div #(
    parameter int RLD_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             freeze,
    input  logic             bypass,
    input  logic             idle_lvl,
    input  logic [RLD_W-1:0] reload,
    output logic             tick,
    output logic             sclk
);

    logic [RLD_W-1:0] cnt_q;
    logic [RLD_W-1:0] limit;
    logic             sclk_q;

    assign limit = bypass ? '0 : reload;
    assign tick  = run && !freeze && (cnt_q == limit);
    assign sclk  = sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            sclk_q <= idle_lvl;
        end else if (!run) begin
            cnt_q  <= '0;
            sclk_q <= idle_lvl;
        end else if (!freeze) begin
            if (cnt_q == limit) begin
                cnt_q  <= '0;
                sclk_q <= ~sclk_q;
            end else begin
                cnt_q <= cnt_q + RLD_W'(1);
            end
        end
    end

endmodule

// File: rtl/spi_sclk_sync.sv
module spi_sclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic idle_lvl,
    input  logic pin,
    output logic edge_stb
);

    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= {STAGES{idle_lvl}};
            last_q  <= idle_lvl;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin};
            last_q  <= chain_q[STAGES-1];
        end
    end

    assign edge_stb = chain_q[STAGES-1] ^ last_q;

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
    import spi_eng_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  frame_shape_t        shape,
    input  logic                start,
    input  logic                tx_wr,
    input  logic [MAX_BITS-1:0] tx_data,
    input  logic                edge_stb,
    input  logic                sdi,
    input  logic                rx_rd,
    output logic                busy,
    output logic                sdo,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                rx_full
);

    logic                busy_q;
    logic [ECNT_W-1:0]   ecnt_q;
    logic [MAX_BITS-1:0] tx_buf_q;
    logic [MAX_BITS-1:0] rx_buf_q;
    logic [MAX_BITS-1:0] rx_data_q;
    logic                full_q;

    logic [ECNT_W-1:0]   e_cur;
    logic [ECNT_W-1:0]   ecnt_m1;
    logic                at_last;
    logic                samp;
    logic [LEN_W-1:0]    in_lane;
    logic [LEN_W-1:0]    out_pos;
    logic [LEN_W-1:0]    out_lane;
    logic [MAX_BITS-1:0] rx_next;

    // Edge being executed now; a slave starts counting from zero on its first edge.
    assign e_cur   = busy_q ? ecnt_q : '0;
    assign at_last = (e_cur == final_edge(shape.len_m1));
    assign samp    = edge_stb && (e_cur[0] == shape.cpha);
    assign in_lane = lane_of(e_cur[ECNT_W-1:1], shape.len_m1, shape.lsb_first);

    always_comb begin
        rx_next = busy_q ? rx_buf_q : '0;
        if (samp) begin
            rx_next[in_lane] = sdi;
        end
    end

    // Output bit: phase 0 advances after each trailing edge, phase 1 on each leading edge.
    assign ecnt_m1  = ecnt_q - ECNT_W'(1);
    assign out_pos  = (shape.cpha && (ecnt_q != '0)) ? ecnt_m1[ECNT_W-1:1]
                                                     : ecnt_q[ECNT_W-1:1];
    assign out_lane = lane_of(out_pos, shape.len_m1, shape.lsb_first);
    assign sdo      = tx_buf_q[out_lane];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q    <= 1'b0;
            ecnt_q    <= '0;
            tx_buf_q  <= '0;
            rx_buf_q  <= '0;
            rx_data_q <= '0;
            full_q    <= 1'b0;
        end else begin
            if (tx_wr && !busy_q) begin
                tx_buf_q <= tx_data;
            end

            if (start) begin
                busy_q   <= 1'b1;
                ecnt_q   <= '0;
                rx_buf_q <= '0;
            end else if (edge_stb) begin
                rx_buf_q <= rx_next;
                if (at_last) begin
                    busy_q    <= 1'b0;
                    ecnt_q    <= '0;
                    rx_data_q <= rx_next;
                end else begin
                    busy_q <= 1'b1;
                    ecnt_q <= e_cur + ECNT_W'(1);
                end
            end

            // A completing character wins over a read in the same cycle.
            if (edge_stb && at_last && !start) begin
                full_q <= 1'b1;
            end else if (rx_rd) begin
                full_q <= 1'b0;
            end
        end
    end

    assign busy    = busy_q;
    assign rx_data = rx_data_q;
    assign rx_full = full_q;

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_eng_pkg::*;
#(
    parameter int RLD_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                mode_master,
    input  logic                cpol,
    input  logic                cpha,
    input  logic                lsb_first,
    input  logic [LEN_W-1:0]    char_len,
    input  logic [RLD_W-1:0]    reload,
    input  logic                div_bypass,
    input  logic                debug_halt,
    input  logic                debug_run,
    input  logic                tx_wr,
    input  logic [MAX_BITS-1:0] tx_data,
    input  logic                rx_rd,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                busy,
    output logic                rxfull_irq,
    input  logic                sclk_in,
    output logic                sclk_out,
    input  logic                sdi,
    output logic                sdo
);

    role_e        role;
    frame_shape_t shape;
    logic         is_master;
    logic         freeze;
    logic         start;
    logic         core_busy;
    logic         div_tick;
    logic         div_sclk;
    logic         pin_edge;
    logic         edge_stb;

    assign role      = role_e'(mode_master);
    assign is_master = (role == ROLE_MASTER);
    assign shape     = '{lsb_first: lsb_first, cpha: cpha, len_m1: char_len};

    // Debug halt only suspends the master's divider; the slave path never sees it.
    assign freeze    = is_master && debug_halt && !debug_run;
    assign start     = is_master && tx_wr && !core_busy;

    spi_baud_div #(
        .RLD_W(RLD_W)
    ) u_div (
        .clk     (clk),
        .rst     (rst),
        .run     (is_master && core_busy),
        .freeze  (freeze),
        .bypass  (div_bypass),
        .idle_lvl(cpol),
        .reload  (reload),
        .tick    (div_tick),
        .sclk    (div_sclk)
    );

    spi_sclk_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .idle_lvl(cpol),
        .pin     (sclk_in),
        .edge_stb(pin_edge)
    );

    assign edge_stb = is_master ? div_tick : pin_edge;

    spi_shift_core u_core (
        .clk     (clk),
        .rst     (rst),
        .shape   (shape),
        .start   (start),
        .tx_wr   (tx_wr),
        .tx_data (tx_data),
        .edge_stb(edge_stb),
        .sdi     (sdi),
        .rx_rd   (rx_rd),
        .busy    (core_busy),
        .sdo     (sdo),
        .rx_data (rx_data),
        .rx_full (rxfull_irq)
    );

    assign busy     = core_busy;
    assign sclk_out = (is_master && core_busy) ? div_sclk : cpol;

endmodule

// File: rtl/spi_shift_engine_chk.sv
module spi_shift_engine_chk (
    input logic clk,
    input logic rst,
    input logic mode_master,
    input logic cpol,
    input logic debug_halt,
    input logic debug_run,
    input logic tx_wr,
    input logic rx_rd,
    input logic busy,
    input logic rxfull_irq,
    input logic sclk_out,
    input logic sdo
);

    logic frz;
    assign frz = mode_master && debug_halt && !debug_run;

    // R2: an idle master accepts a write and is busy on the next cycle
    a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
        (mode_master && tx_wr && !busy) |=> busy);

    // R5: a master transfer begins with SCLK at its idle polarity
    a_r5_sclk_idle_at_start: assert property (@(posedge clk) disable iff (rst)
        (mode_master && $rose(busy)) |-> (sclk_out == cpol));

    // R8: the end of a character raises the receive-full interrupt
    a_r8_done_sets_full: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> rxfull_irq);

    // R8: a read with no character completing clears the flag
    a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rx_rd && !busy) |=> !rxfull_irq);

    // R9: a frozen master keeps its pins where they were
    a_r9_freeze_hold: assert property (@(posedge clk) disable iff (rst)
        ($past(frz && busy) && busy) |-> ($stable(sclk_out) && $stable(sdo)));

endmodule

bind spi_shift_engine spi_shift_engine_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode_master(mode_master),
    .cpol       (cpol),
    .debug_halt (debug_halt),
    .debug_run  (debug_run),
    .tx_wr      (tx_wr),
    .rx_rd      (rx_rd),
    .busy       (busy),
    .rxfull_irq (rxfull_irq),
    .sclk_out   (sclk_out),
    .sdo        (sdo)
);

// File: tb/spi_shift_engine_test.sv
module spi_shift_engine_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_master = 1'b1;
    logic        cpol = 1'b0;
    logic        cpha = 1'b0;
    logic        lsb_first = 1'b0;
    logic [3:0]  char_len = 4'h7;
    logic [15:0] reload = 16'h0000;
    logic        div_bypass = 1'b0;
    logic        debug_halt = 1'b0;
    logic        debug_run = 1'b0;
    logic        tx_wr = 1'b0;
    logic [15:0] tx_data = 16'h0000;
    logic        rx_rd = 1'b0;
    logic [15:0] rx_data;
    logic        busy;
    logic        rxfull_irq;
    logic        sclk_in = 1'b0;
    logic        sclk_out;
    logic        sdi = 1'b0;
    logic        sdo;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_shift_engine uut (
        .clk(clk), .rst(rst), .mode_master(mode_master), .cpol(cpol), .cpha(cpha),
        .lsb_first(lsb_first), .char_len(char_len), .reload(reload),
        .div_bypass(div_bypass), .debug_halt(debug_halt), .debug_run(debug_run),
        .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd), .rx_data(rx_data),
        .busy(busy), .rxfull_irq(rxfull_irq), .sclk_in(sclk_in), .sclk_out(sclk_out),
        .sdi(sdi), .sdo(sdo)
    );

    task automatic check(input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    function automatic int bl(input int k, input int lm1, input bit lsbf);
        return lsbf ? k : (lm1 - k);
    endfunction

    task automatic test_reset();
        check("R1 busy after reset", int'(busy), 0);
        check("R1 rxfull after reset", int'(rxfull_irq), 0);
        check("R1 rx_data after reset", int'(rx_data), 0);
        check("R1 sclk idle after reset", int'(sclk_out), 0);
    endtask

    task automatic run_master(input bit cp, input bit ph, input bit lsbf, input int lm1,
                              input int rld, input bit byp, input logic [15:0] txw,
                              input logic [15:0] sw, input int halt_at, input int halt_len,
                              input bit drun, input bit wr_mid, input string tag);
        int n;
        int hp;
        int j;
        int edges;
        int last_j;
        int samples;
        int bad_int;
        int hold_bad;
        int exp_end;
        logic [15:0] m;
        logic [15:0] capt;
        logic prev_s;
        logic prev_o;
        logic ref_s;
        logic ref_o;
        n = lm1 + 1;
        hp = byp ? 1 : rld + 1;
        m = 16'((32'd1 << n) - 1);
        j = 0; edges = 0; last_j = 0; samples = 0; bad_int = 0; hold_bad = 0;
        capt = '0; ref_s = 1'b0; ref_o = 1'b0;
        mode_master = 1'b1; cpol = cp; cpha = ph; lsb_first = lsbf;
        char_len = 4'(lm1); reload = 16'(rld); div_bypass = byp;
        debug_run = drun; debug_halt = 1'b0;
        sdi = sw[bl(0, lm1, lsbf)];
        repeat (3) @(negedge clk);
        tx_data = txw; tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
        check({tag, " R2 busy after write"}, int'(busy), 1);
        prev_s = sclk_out; prev_o = sdo;
        while (busy && j < 20000) begin
            @(negedge clk);
            j++;
            if (sclk_out !== prev_s) begin
                edges++;
                if (j - last_j != hp) bad_int++;
                last_j = j;
                if (((edges - 1) % 2) == int'(ph)) begin
                    capt[bl(samples, lm1, lsbf)] = prev_o;
                    samples++;
                    if (samples < n) sdi = sw[bl(samples, lm1, lsbf)];
                end
            end
            prev_s = sclk_out; prev_o = sdo;
            if (wr_mid && j == 3) begin
                tx_data = ~txw; tx_wr = 1'b1;
            end
            if (wr_mid && j == 4) tx_wr = 1'b0;
            if (halt_len > 0) begin
                if (j == halt_at) begin
                    debug_halt = 1'b1; ref_s = sclk_out; ref_o = sdo;
                end else if (j > halt_at && j <= halt_at + halt_len) begin
                    if (!drun && (sclk_out !== ref_s || sdo !== ref_o || busy !== 1'b1))
                        hold_bad++;
                    if (j == halt_at + halt_len) debug_halt = 1'b0;
                end
            end
        end
        exp_end = (halt_len > 0 && !drun) ? 2 * n * hp + halt_len : 2 * n * hp;
        check({tag, " R2 edge count"}, edges, 2 * n);
        check({tag, " R2 cycles to completion"}, j, exp_end);
        if (!(halt_len > 0 && !drun))
            check({tag, " R3 R4 half period violations"}, bad_int, 0);
        check({tag, " R5 R6 R7 word seen on SDO"}, int'(capt & m), int'(txw & m));
        check({tag, " R5 R6 R7 rx_data"}, int'(rx_data), int'(sw & m));
        check({tag, " R8 rxfull on completion"}, int'(rxfull_irq), 1);
        check({tag, " R2 sclk rests at cpol"}, int'(sclk_out), int'(cp));
        if (halt_len > 0 && !drun) check({tag, " R9 pins held while frozen"}, hold_bad, 0);
        if (halt_len > 0 && drun) check({tag, " R10 no delay with debug run"}, j, 2 * n * hp);
        if (wr_mid) check({tag, " R12 write during busy ignored"}, int'(capt & m), int'(txw & m));
        repeat (3) @(negedge clk);
        check({tag, " R8 rxfull held until read"}, int'(rxfull_irq), 1);
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
        check({tag, " R8 rxfull cleared by read"}, int'(rxfull_irq), 0);
    endtask

    task automatic run_slave(input bit cp, input bit ph, input bit lsbf, input int lm1,
                             input logic [15:0] txw, input logic [15:0] sw,
                             input bit dbg, input string tag);
        int n;
        int k;
        int idx;
        logic [15:0] m;
        logic [15:0] capt;
        n = lm1 + 1;
        m = 16'((32'd1 << n) - 1);
        k = 0; capt = '0;
        mode_master = 1'b1; cpol = cp; cpha = ph; lsb_first = lsbf;
        char_len = 4'(lm1); sclk_in = cp; debug_halt = 1'b0;
        repeat (4) @(negedge clk);
        mode_master = 1'b0; reload = 16'h0005; div_bypass = 1'b1;
        debug_halt = dbg; debug_run = 1'b0;
        repeat (4) @(negedge clk);
        tx_data = txw; tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
        check({tag, " R11 slave write does not start"}, int'(busy), 0);
        sdi = sw[bl(0, lm1, lsbf)];
        for (int e = 0; e < 2 * n; e++) begin
            repeat (4) @(negedge clk);
            if ((e % 2) == int'(ph)) begin
                capt[bl(k, lm1, lsbf)] = sdo;
                k++;
            end
            sclk_in = ~sclk_in;
            if ((e % 2) != int'(ph)) begin
                idx = ph ? e / 2 : (e + 1) / 2;
                if (idx < n) sdi = sw[bl(idx, lm1, lsbf)];
            end
        end
        repeat (5) @(negedge clk);
        check({tag, " R11 slave idle after character"}, int'(busy), 0);
        check({tag, " R11 R8 slave rxfull"}, int'(rxfull_irq), 1);
        check({tag, " R11 R6 slave rx_data"}, int'(rx_data), int'(sw & m));
        check({tag, " R11 R5 slave word on SDO"}, int'(capt & m), int'(txw & m));
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
        check({tag, " R8 slave read clears"}, int'(rxfull_irq), 0);
        debug_halt = 1'b0;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        run_master(1'b0, 1'b0, 1'b0, 7, 2, 1'b0, 16'h00A5, 16'h003C, 0, 0, 1'b0, 1'b0, "mode0 msb");
        run_master(1'b0, 1'b1, 1'b1, 7, 0, 1'b0, 16'h0096, 16'h00E1, 0, 0, 1'b0, 1'b0, "mode1 lsb");
        run_master(1'b1, 1'b0, 1'b0, 11, 1, 1'b0, 16'h0B3D, 16'h05C6, 0, 0, 1'b0, 1'b0, "mode2 12bit");
        run_master(1'b1, 1'b1, 1'b1, 15, 3, 1'b0, 16'hC35A, 16'h7E81, 0, 0, 1'b0, 1'b0, "mode3 16bit");
        run_master(1'b0, 1'b0, 1'b0, 4, 7, 1'b1, 16'h0015, 16'h000A, 0, 0, 1'b0, 1'b0, "bypass");
        run_master(1'b0, 1'b1, 1'b0, 7, 1, 1'b0, 16'h005E, 16'h00A7, 0, 0, 1'b0, 1'b1, "busy write");
        run_master(1'b0, 1'b0, 1'b0, 7, 3, 1'b0, 16'h00C9, 16'h0036, 6, 25, 1'b0, 1'b0, "freeze");
        run_master(1'b1, 1'b0, 1'b1, 7, 3, 1'b0, 16'h0071, 16'h008E, 6, 25, 1'b1, 1'b0, "debug run");
        run_slave(1'b0, 1'b0, 1'b0, 7, 16'h00D2, 16'h004B, 1'b1, "slave mode0 halted");
        run_slave(1'b1, 1'b1, 1'b1, 4, 16'h0019, 16'h0006, 1'b0, "slave mode3 5bit");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule